// File: doc/BRIEF.md
# Prioritized Data-Side Fault Status Capture

This block records why and where a data-side memory access failed. Each clock cycle it may be handed a fault strobe together with a vector of fault request lines. It also receives the access address, the access direction, the kind of bus error response, and some detail about any parity/ECC error. When more than one request line is active, a fixed priority selects the single fault to record. The block then builds a 32-bit status word that holds a split 5-bit cause code and two qualifier bits.

What happens to the fault address register depends on the kind of fault. Precise faults load the access address into it. Imprecise faults and debug events leave it as it was. A parity/ECC fault also fills an auxiliary register with the cache way, the error source, a recoverable flag and the array index.

Privileged software reads and writes the three registers through a plain register port. Read data is combinational and appears in the same cycle. A user-mode access is refused. The fault input is a single-cycle strobe with no ready signal: it is never back-pressured, and any fault presented on the strobe is captured on the next rising edge.

Top module: `dfault_capture`

## Requirements
- R1: Reset sets the status, auxiliary and address registers to zero.
- R2: Request line i has priority over line j when i < j. The lines are: 0 alignment, 1 background, 2 permission, 3 precise external, 4 imprecise external, 5 precise parity/ECC, 6 imprecise parity/ECC, 7 debug. Only the highest-priority active line is recorded.
- R3: The status word holds the 5-bit cause code with code bit 4 at word bit 10 and code bits 3:0 at word bits 3:0. The codes are: alignment 00001, background 00000, permission 01101, precise external 01000, imprecise external 10110, precise parity 11001, imprecise parity 11000, debug 00010.
- R4: Status bit 12 equals `flt_slverr` (1 = slave error, 0 = decode error) for the two external faults. It is 0 for every other fault.
- R5: Status bit 11 equals `flt_write` (0 = read, 1 = write) of the captured access.
- R6: The address register loads `flt_addr` for alignment, background, permission, precise external and precise parity faults. It keeps its value for imprecise external, imprecise parity and debug faults.
- R7: On either parity/ECC fault the auxiliary register is loaded with way at bits 27:24, source at 23:22, recoverable at 21 and index at 13:5; all its other bits are 0. The auxiliary register keeps its value on any other fault.
- R8: A capture happens on the rising edge at which `flt_valid` is high and at least one request line is high. Request lines are ignored while `flt_valid` is low.
- R9: Register select 0 addresses the status register, 1 the auxiliary register and 2 the address register. A privileged read drives the selected value on `reg_rdata` in the same cycle. Select 3 reads zero and ignores writes.
- R10: A privileged write replaces the writable bits of the selected register. The writable bits are 12, 11, 10 and 3:0 of the status register, 27:21 and 13:5 of the auxiliary register, and all bits of the address register. All other bits read zero.
- R11: An access with `reg_priv` low raises `reg_err`, reads zero and changes no register.
- R12: If a capture and a privileged write fall in the same cycle, the capture wins for each register it updates. The write still lands in any register the capture leaves alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_valid | input | 1 | Fault strobe |
| flt_req | input | 8 | Fault request lines, index order per R2 |
| flt_addr | input | ADDR_W | Faulting access address |
| flt_write | input | 1 | Access direction, 1 = write |
| flt_slverr | input | 1 | External response kind, 1 = slave error |
| flt_way | input | 4 | Cache way(s) of a parity/ECC error |
| flt_src | input | 2 | Error source: 00 cache/bus, 01 TCM A, 10 TCM B |
| flt_recov | input | 1 | Error is recoverable |
| flt_index | input | 9 | Array index of a parity/ECC error |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 2 | Register select per R9 |
| reg_priv | input | 1 | Access is privileged |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| reg_err | output | 1 | Unprivileged access refused |

## Verification
The bench builds the block with the default ADDR_W of 32. This lets it use addresses with bits set at both ends of the word, so a load, a hold or a truncation of the address register can be seen on read-back. Every fault kind is raised on its own and in overlapping combinations, with direction and response kind varied. This exposes the code placement, the qualifier bits and the per-kind address rule. Write-masking, user-mode refusal and same-cycle capture/write collisions are each driven so that their effect is visible only through later privileged reads.

// File: rtl/dfault_pkg.sv
package dfault_pkg;

  localparam int NKIND = 8;
  localparam int KW    = $clog2(NKIND);

  typedef enum logic [KW-1:0] {
    FK_ALIGN  = 3'd0,
    FK_BKGND  = 3'd1,
    FK_PERM   = 3'd2,
    FK_EXT_P  = 3'd3,
    FK_EXT_I  = 3'd4,
    FK_PAR_P  = 3'd5,
    FK_PAR_I  = 3'd6,
    FK_DEBUG  = 3'd7
  } fkind_e;

  localparam logic [31:0] STAT_WMASK = 32'h0000_1C0F;
  localparam logic [31:0] AUX_WMASK  = 32'h0FE0_3FE0;

  localparam logic [1:0] SEL_STAT = 2'd0;
  localparam logic [1:0] SEL_AUX  = 2'd1;
  localparam logic [1:0] SEL_ADDR = 2'd2;

  function automatic logic [4:0] fkind_code(fkind_e k);
    case (k)
      FK_ALIGN: return 5'b00001;
      FK_BKGND: return 5'b00000;
      FK_PERM:  return 5'b01101;
      FK_EXT_P: return 5'b01000;
      FK_EXT_I: return 5'b10110;
      FK_PAR_P: return 5'b11001;
      FK_PAR_I: return 5'b11000;
      default:  return 5'b00010;
    endcase
  endfunction

  function automatic logic fkind_is_ext(fkind_e k);
    return (k == FK_EXT_P) || (k == FK_EXT_I);
  endfunction

  function automatic logic fkind_is_par(fkind_e k);
    return (k == FK_PAR_P) || (k == FK_PAR_I);
  endfunction

  function automatic logic fkind_loads_addr(fkind_e k);
    return (k == FK_ALIGN) || (k == FK_BKGND) || (k == FK_PERM) ||
           (k == FK_EXT_P) || (k == FK_PAR_P);
  endfunction

endpackage

// File: rtl/fault_prio_enc.sv
module fault_prio_enc #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end

  // R2: the winner is an active line and no line of higher priority is active
  a_r2_winner_is_top: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0)));

  a_r2_any_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) == any);

endmodule

// File: rtl/fault_word_fmt.sv
module fault_word_fmt
  import dfault_pkg::*;
#(
  parameter int WAY_W = 4,
  parameter int IDX_W = 9
) (
  input  fkind_e           kind,
  input  logic             write,
  input  logic             slverr,
  input  logic [WAY_W-1:0] way,
  input  logic [1:0]       src,
  input  logic             recov,
  input  logic [IDX_W-1:0] index,
  output logic [31:0]      stat_word,
  output logic [31:0]      aux_word,
  output logic             load_addr,
  output logic             load_aux
);

  localparam int WAY_LSB = 24;
  localparam int SRC_LSB = 22;
  localparam int REC_BIT = 21;
  localparam int IDX_LSB = 5;

  logic [4:0] code;

  always_comb begin
    code = fkind_code(kind);
    stat_word       = '0;
    stat_word[12]   = fkind_is_ext(kind) & slverr;
    stat_word[11]   = write;
    stat_word[10]   = code[4];
    stat_word[3:0]  = code[3:0];

    aux_word = '0;
    aux_word[WAY_LSB +: WAY_W] = way;
    aux_word[SRC_LSB +: 2]     = src;
    aux_word[REC_BIT]          = recov;
    aux_word[IDX_LSB +: IDX_W] = index;

    load_addr = fkind_loads_addr(kind);
    load_aux  = fkind_is_par(kind);
  end

endmodule

// File: rtl/dfault_capture.sv
module dfault_capture
  import dfault_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flt_valid,
  input  logic [7:0]        flt_req,
  input  logic [ADDR_W-1:0] flt_addr,
  input  logic              flt_write,
  input  logic              flt_slverr,
  input  logic [3:0]        flt_way,
  input  logic [1:0]        flt_src,
  input  logic              flt_recov,
  input  logic [8:0]        flt_index,
  input  logic              reg_en,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic              reg_priv,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_err
);

  logic              any_req;
  logic [KW-1:0]     win_idx;
  fkind_e            win_kind;
  logic [31:0]       hw_stat, hw_aux;
  logic              hw_ld_addr, hw_ld_aux;
  logic              cap;
  logic              sw_wr, sw_rd;
  logic [31:0]       stat_q, aux_q;
  logic [ADDR_W-1:0] addr_q;

  fault_prio_enc #(.N(NKIND)) u_prio (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (flt_req),
    .any   (any_req),
    .idx   (win_idx)
  );

  assign win_kind = fkind_e'(win_idx);

  fault_word_fmt #(.WAY_W(4), .IDX_W(9)) u_fmt (
    .kind      (win_kind),
    .write     (flt_write),
    .slverr    (flt_slverr),
    .way       (flt_way),
    .src       (flt_src),
    .recov     (flt_recov),
    .index     (flt_index),
    .stat_word (hw_stat),
    .aux_word  (hw_aux),
    .load_addr (hw_ld_addr),
    .load_aux  (hw_ld_aux)
  );

  assign cap   = flt_valid & any_req;
  assign sw_wr = reg_en & reg_priv & reg_wr;
  assign sw_rd = reg_en & reg_priv & ~reg_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      aux_q  <= '0;
      addr_q <= '0;
    end else begin
      if (cap)
        stat_q <= hw_stat;
      else if (sw_wr && reg_sel == SEL_STAT)
        stat_q <= reg_wdata & STAT_WMASK;

      if (cap && hw_ld_aux)
        aux_q <= hw_aux;
      else if (sw_wr && reg_sel == SEL_AUX)
        aux_q <= reg_wdata & AUX_WMASK;

      if (cap && hw_ld_addr)
        addr_q <= flt_addr;
      else if (sw_wr && reg_sel == SEL_ADDR)
        addr_q <= reg_wdata[ADDR_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (sw_rd) begin
      case (reg_sel)
        SEL_STAT: reg_rdata = stat_q;
        SEL_AUX:  reg_rdata = aux_q;
        SEL_ADDR: reg_rdata = 32'(addr_q);
        default:  reg_rdata = '0;
      endcase
    end
  end

  assign reg_err = reg_en & ~reg_priv;

  // R11: a refused access leaves every register as it was
  a_r11_user_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && !reg_priv && !cap) |=> ($stable(stat_q) && $stable(aux_q) && $stable(addr_q)));

  a_r11_user_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && !reg_priv) |-> (reg_rdata == '0 && reg_err));

  // R6: a debug event does not move the address register
  a_r6_debug_holds_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && win_kind == FK_DEBUG && !(sw_wr && reg_sel == SEL_ADDR)) |=> $stable(addr_q));

  // R4: qualifier bit 12 is clear after any non-external capture
  a_r4_bit12_non_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && !fkind_is_ext(win_kind)) |=> (stat_q[12] == 1'b0));

  // R5: direction bit follows the captured access
  a_r5_direction: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (stat_q[11] == $past(flt_write)));

  // R8: nothing moves without a capture or a write
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap && !sw_wr) |=> ($stable(stat_q) && $stable(aux_q) && $stable(addr_q)));

  // R10: bits outside the writable set stay zero
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~STAT_WMASK) == '0) && ((aux_q & ~AUX_WMASK) == '0));

endmodule

// File: tb/dfault_capture_test.sv
`timescale 1ns/1ps
module dfault_capture_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flt_valid = 1'b0;
  logic [7:0]  flt_req = '0;
  logic [31:0] flt_addr = '0;
  logic        flt_write = 1'b0;
  logic        flt_slverr = 1'b0;
  logic [3:0]  flt_way = '0;
  logic [1:0]  flt_src = '0;
  logic        flt_recov = 1'b0;
  logic [8:0]  flt_index = '0;
  logic        reg_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic        reg_priv = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_err;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] d;
    logic        e;
    string       tag;
  } exp_t;
  exp_t expq[$];

  logic [31:0] m_stat = '0, m_aux = '0, m_addr = '0;

  always #2.5 clk = ~clk;

  dfault_capture #(.ADDR_W(32)) uut (
    .clk(clk), .rst_n(rst_n),
    .flt_valid(flt_valid), .flt_req(flt_req), .flt_addr(flt_addr),
    .flt_write(flt_write), .flt_slverr(flt_slverr), .flt_way(flt_way),
    .flt_src(flt_src), .flt_recov(flt_recov), .flt_index(flt_index),
    .reg_en(reg_en), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_priv(reg_priv),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err)
  );

  function automatic logic [4:0] code_of(int k);
    case (k)
      0: return 5'b00001;
      1: return 5'b00000;
      2: return 5'b01101;
      3: return 5'b01000;
      4: return 5'b10110;
      5: return 5'b11001;
      6: return 5'b11000;
      default: return 5'b00010;
    endcase
  endfunction

  // monitor: compare every read against the front of the scoreboard
  always @(negedge clk) begin
    if (reg_en && !reg_wr) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty: actual %h", reg_rdata);
      end else begin
        exp_t x;
        x = expq.pop_front();
        if (reg_rdata !== x.d || reg_err !== x.e) begin
          errors++;
          $display("FAIL %s: actual data %h err %b, expected data %h err %b",
                   x.tag, reg_rdata, reg_err, x.d, x.e);
        end
      end
    end
  end

  // model update for a fault, built from R2..R7
  task automatic model_fault(logic [7:0] req, logic [31:0] a, logic w, logic s,
                             logic [3:0] way, logic [1:0] src, logic rc, logic [8:0] idx);
    int k;
    logic [4:0] c;
    k = -1;
    for (int i = 7; i >= 0; i--) if (req[i]) k = i;
    if (k < 0) return;
    c = code_of(k);
    m_stat = '0;
    m_stat[12] = ((k == 3) || (k == 4)) ? s : 1'b0;
    m_stat[11] = w;
    m_stat[10] = c[4];
    m_stat[3:0] = c[3:0];
    if (k == 0 || k == 1 || k == 2 || k == 3 || k == 5) m_addr = a;
    if (k == 5 || k == 6) begin
      m_aux = '0;
      m_aux[27:24] = way;
      m_aux[23:22] = src;
      m_aux[21] = rc;
      m_aux[13:5] = idx;
    end
  endtask

  task automatic set_fault(logic [7:0] req, logic [31:0] a, logic w, logic s,
                           logic [3:0] way, logic [1:0] src, logic rc, logic [8:0] idx);
    flt_valid = 1'b1; flt_req = req; flt_addr = a; flt_write = w; flt_slverr = s;
    flt_way = way; flt_src = src; flt_recov = rc; flt_index = idx;
  endtask

  task automatic fault(logic [7:0] req, logic [31:0] a, logic w, logic s,
                       logic [3:0] way, logic [1:0] src, logic rc, logic [8:0] idx);
    set_fault(req, a, w, s, way, src, rc, idx);
    @(posedge clk); #1;
    flt_valid = 1'b0; flt_req = '0;
    model_fault(req, a, w, s, way, src, rc, idx);
  endtask

  task automatic swr(logic [1:0] sel, logic [31:0] d, logic priv);
    reg_en = 1'b1; reg_wr = 1'b1; reg_sel = sel; reg_wdata = d; reg_priv = priv;
    @(posedge clk); #1;
    reg_en = 1'b0; reg_wr = 1'b0;
    if (priv) begin
      if (sel == 2'd0) m_stat = d & 32'h0000_1C0F;
      if (sel == 2'd1) m_aux  = d & 32'h0FE0_3FE0;
      if (sel == 2'd2) m_addr = d;
    end
  endtask

  task automatic rd(logic [1:0] sel, logic priv, string tag);
    exp_t x;
    x.tag = tag;
    x.e = !priv;
    if (!priv) x.d = '0;
    else case (sel)
      2'd0: x.d = m_stat;
      2'd1: x.d = m_aux;
      2'd2: x.d = m_addr;
      default: x.d = '0;
    endcase
    expq.push_back(x);
    reg_en = 1'b1; reg_wr = 1'b0; reg_sel = sel; reg_priv = priv;
    @(posedge clk); #1;
    reg_en = 1'b0;
  endtask

  task automatic rd_all(string tag);
    rd(2'd0, 1'b1, {tag, " status"});
    rd(2'd1, 1'b1, {tag, " aux"});
    rd(2'd2, 1'b1, {tag, " addr"});
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state, R9 select 3 reads zero
    rd_all("R1 reset");
    rd(2'd3, 1'b1, "R9 unused select");

    // R3 R4 R5 R6 R7: each kind alone, varied direction and response
    for (int k = 0; k < 8; k++) begin
      fault(8'(1) << k, 32'h8000_0001 + 32'(k) * 32'h0101_0100, k[0], 1'b1,
            4'(k + 3), 2'(k), k[1], 9'(k * 37 + 1));
      rd_all($sformatf("R3 R4 R5 R6 R7 kind %0d", k));
    end

    // R4: external with decode error response
    fault(8'h08, 32'h1234_5678, 1'b0, 1'b0, 4'h0, 2'd0, 1'b0, 9'd0);
    rd(2'd0, 1'b1, "R4 decode error");

    // R2: overlapping requests
    fault(8'hFE, 32'hDEAD_BEEF, 1'b1, 1'b1, 4'h0, 2'd0, 1'b0, 9'd0);
    rd_all("R2 background wins");
    fault(8'hC0, 32'h0BAD_F00D, 1'b0, 1'b1, 4'hA, 2'd2, 1'b1, 9'h1FF);
    rd_all("R2 imprecise parity over debug");
    fault(8'h90, 32'hFFFF_FFFF, 1'b1, 1'b1, 4'h5, 2'd1, 1'b1, 9'h0AA);
    rd_all("R2 imprecise external over debug");
    fault(8'h24, 32'h7000_0004, 1'b0, 1'b1, 4'hF, 2'd3, 1'b1, 9'h155);
    rd_all("R2 permission over precise parity");

    // R8: requests without strobe are ignored
    flt_valid = 1'b0; flt_req = 8'h01; flt_addr = 32'h5555_AAAA;
    @(posedge clk); #1;
    flt_req = '0;
    rd_all("R8 no strobe");
    // strobe without requests
    flt_valid = 1'b1; flt_req = 8'h00;
    @(posedge clk); #1;
    flt_valid = 1'b0;
    rd_all("R8 empty request");

    // R10: masked software writes
    swr(2'd0, 32'hFFFF_FFFF, 1'b1);
    swr(2'd1, 32'hFFFF_FFFF, 1'b1);
    swr(2'd2, 32'hC0DE_0123, 1'b1);
    swr(2'd3, 32'hFFFF_FFFF, 1'b1);
    rd_all("R10 write all ones");
    rd(2'd3, 1'b1, "R9 R10 select 3 after write");
    swr(2'd0, 32'h0000_0000, 1'b1);
    rd(2'd0, 1'b1, "R10 status restore");

    // R11: user-mode access
    rd(2'd0, 1'b0, "R11 user read status");
    rd(2'd2, 1'b0, "R11 user read addr");
    swr(2'd0, 32'h0000_1C0F, 1'b0);
    swr(2'd1, 32'h0FE0_3FE0, 1'b0);
    swr(2'd2, 32'h0000_0000, 1'b0);
    rd_all("R11 after user writes");

    // R12: capture beats write on the same register
    reg_en = 1'b1; reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 32'h0000_000F; reg_priv = 1'b1;
    set_fault(8'h08, 32'hAAAA_0000, 1'b1, 1'b1, 4'h0, 2'd0, 1'b0, 9'd0);
    @(posedge clk); #1;
    reg_en = 1'b0; reg_wr = 1'b0; flt_valid = 1'b0; flt_req = '0;
    model_fault(8'h08, 32'hAAAA_0000, 1'b1, 1'b1, 4'h0, 2'd0, 1'b0, 9'd0);
    rd_all("R12 capture wins status and addr");

    // R12: write lands where the capture does not touch (debug holds addr)
    reg_en = 1'b1; reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = 32'h1357_9BDF; reg_priv = 1'b1;
    set_fault(8'h80, 32'hFFFF_0000, 1'b0, 1'b0, 4'h0, 2'd0, 1'b0, 9'd0);
    @(posedge clk); #1;
    reg_en = 1'b0; reg_wr = 1'b0; flt_valid = 1'b0; flt_req = '0;
    model_fault(8'h80, 32'hFFFF_0000, 1'b0, 1'b0, 4'h0, 2'd0, 1'b0, 9'd0);
    m_addr = 32'h1357_9BDF;
    rd_all("R12 write lands on addr");

    // R12: aux written by software during a non-parity capture
    reg_en = 1'b1; reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = 32'h0120_0020; reg_priv = 1'b1;
    set_fault(8'h01, 32'h0000_0003, 1'b1, 1'b0, 4'h0, 2'd0, 1'b0, 9'd0);
    @(posedge clk); #1;
    reg_en = 1'b0; reg_wr = 1'b0; flt_valid = 1'b0; flt_req = '0;
    model_fault(8'h01, 32'h0000_0003, 1'b1, 1'b0, 4'h0, 2'd0, 1'b0, 9'd0);
    m_aux = 32'h0120_0020 & 32'h0FE0_3FE0;
    rd_all("R12 write lands on aux");

    @(posedge clk); #1;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL scoreboard leftover: actual %0d, expected 0", expq.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule